// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block fills the two threshold registers used by a FIFO's flag logic, the almost-full offset and the almost-empty offset, from a one-bit serial line after reset. On each rising clock edge where the active-low shift enable is asserted, the bit on the serial data line is taken into a single shift chain that spans both offsets. The sender may pause for any number of cycles between bits; only qualified edges advance the load.

Until every bit of both offsets has been taken, the block holds its load-done output low. The FIFO write port uses that output as its input-ready: a write request presented while load-done is low is dropped, and only once load-done is high is a request passed on as an accepted write. After completion the shift enable is ignored until the next reset, so the offsets stay fixed for the life of that reset period.

Top module: `flag_offset_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `load_done` and `wr_accept` are 0 and both offset outputs read 0.
- R2: A bit is taken only on a rising edge where `sen_n` is 0; on an edge where `sen_n` is 1 the offset outputs keep their value whatever `sd` carries.
- R3: The bit order is fixed: the first bit taken is the almost-full offset's most significant bit, continuing through its least significant bit, then the almost-empty offset from its most significant bit down to its least significant bit, which is the final bit.
- R4: Any number of idle cycles (zero or more) may separate consecutive bits without changing the loaded values.
- R5: `load_done` rises in the cycle right after the edge that takes the final bit (bit number 2*OFS_W) and is 0 before that edge.
- R6: Once `load_done` is 1, further edges with `sen_n` low change neither offset and `load_done` stays 1 until reset.
- R7: `wr_accept` equals `wr_req` when `load_done` is 1 and is 0 otherwise, so write requests made before the load completes are dropped.
- R8: Asserting reset in the middle of a load discards the partial load; the next load starts again from the almost-full offset's most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Active-low serial shift enable |
| sd | input | 1 | Serial offset data bit |
| wr_req | input | 1 | FIFO write request from the write port |
| af_ofs | output | OFS_W | Almost-full offset |
| ae_ofs | output | OFS_W | Almost-empty offset |
| load_done | output | 1 | High once both offsets are loaded; serves as input-ready |
| wr_accept | output | 1 | Write request passed on to the FIFO |

## Verification
The bench runs a 4-bit-per-offset configuration and loads every pair of almost-full and almost-empty values, so any swap of the two offsets or reversal of bit order shows up as a wrong value on some pair. Idle gaps between bits vary from zero to three cycles, with the data line toggling during gaps, which separates a design that samples only qualified edges from one that samples every edge. Write requests are held high throughout, distinguishing a gate that opens one cycle early or late from the correct one, and extra shift pulses after completion and a reset partway through a load test the hold and restart behaviour.

// File: rtl/fol_pkg.sv
package fol_pkg;
  // Number of serial bits that make up both offsets
  function automatic int total_bits(input int ofs_w);
    return 2 * ofs_w;
  endfunction
endpackage

// File: rtl/fol_bit_counter.sv
module fol_bit_counter #(
  parameter int TOTAL = 18,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(TOTAL - 1)) done <= 1'b1;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOTAL));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cnt_q == CNT_W'(TOTAL));
endmodule

// File: rtl/fol_shift_chain.sv
module fol_shift_chain #(
  parameter int LEN = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           bit_in,
  output logic [LEN-1:0] chain
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else if (take) chain <= {chain[LEN-2:0], bit_in};
  end

  // R2
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(chain));
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int DEPTH = 512,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int TOTAL = fol_pkg::total_bits(OFS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sen_n,
  input  logic             sd,
  input  logic             wr_req,
  output logic [OFS_W-1:0] af_ofs,
  output logic [OFS_W-1:0] ae_ofs,
  output logic             load_done,
  output logic             wr_accept
);
  logic             take;
  logic [TOTAL-1:0] chain;

  assign take = !sen_n && !load_done;

  fol_bit_counter #(.TOTAL(TOTAL)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .done (load_done)
  );

  fol_shift_chain #(.LEN(TOTAL)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .bit_in(sd),
    .chain (chain)
  );

  // First bits in end up at the top of the chain: almost-full offset
  assign af_ofs    = chain[TOTAL-1:OFS_W];
  assign ae_ofs    = chain[OFS_W-1:0];
  assign wr_accept = wr_req && load_done;

  // R2
  sen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n |=> $stable({af_ofs, ae_ofs}));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done && $stable({af_ofs, ae_ofs}));

  // R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> load_done);
endmodule

// File: tb/flag_offset_loader_tb.sv
module flag_offset_loader_tb;
  localparam int DEPTH = 16;
  localparam int W = $clog2(DEPTH);
  localparam int N = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_n = 1'b1;
  logic sd = 1'b0;
  logic wr_req = 1'b1;
  logic [W-1:0] af_ofs, ae_ofs;
  logic load_done, wr_accept;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flag_offset_loader #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sd(sd), .wr_req(wr_req),
    .af_ofs(af_ofs), .ae_ofs(ae_ofs), .load_done(load_done), .wr_accept(wr_accept)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sen_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one bit after 'gap' idle cycles; sd toggles while idle.
  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      sen_n = 1'b1; sd = ~b;
      @(negedge clk);
    end
    sen_n = 1'b0; sd = b;
    @(negedge clk);
    sen_n = 1'b1;
  endtask

  // Full load of pair (y,x); returns with the bench at a negedge after the last bit.
  task automatic load_pair(input int y, input int x, input int seed, input bit deep);
    logic [N-1:0] word;
    word = {y[W-1:0], x[W-1:0]};
    for (int i = 0; i < N; i++) begin
      if (i == N - 1) begin
        // R5 R7: still blocked just before the final bit
        chk("R5", int'(load_done), 0);
        chk("R7", int'(wr_accept), 0);
      end
      send_bit(word[N-1-i], (seed + i) % 4);
      if (deep && i == 2) begin
        // R3: first three bits sit at the chain's low end so far
        chk("R3", int'({af_ofs, ae_ofs}), int'(word[N-1 -: 3]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(load_done), 0);
    chk("R1", int'(wr_accept), 0);
    chk("R1", int'(af_ofs), 0);
    chk("R1", int'(ae_ofs), 0);

    // R2: sen_n high with sd toggling takes nothing
    for (int k = 0; k < 3; k++) begin
      sd = k[0];
      @(negedge clk);
    end
    chk("R2", int'({af_ofs, ae_ofs}), 0);

    // R8: partial load then reset restarts
    send_bit(1'b1, 0);
    send_bit(1'b1, 1);
    do_reset();
    @(negedge clk);
    chk("R8", int'({af_ofs, ae_ofs}), 0);
    load_pair(5, 10, 0, 1'b0);
    chk("R8", int'(af_ofs), 5);
    chk("R8", int'(ae_ofs), 10);

    // R3 R4 R5 R7: sweep every pair with varying gaps
    for (int y = 0; y < DEPTH; y++) begin
      for (int x = 0; x < DEPTH; x++) begin
        do_reset();
        load_pair(y, x, y + x, (y == 9 && x == 6));
        chk("R5", int'(load_done), 1);
        chk("R7", int'(wr_accept), 1);
        chk("R3", int'(af_ofs), y);
        chk("R4", int'(ae_ofs), x);
        if (x == y) begin
          // R6: extra shifting after completion changes nothing
          for (int k = 0; k < 3; k++) send_bit(~k[0], 0);
          chk("R6", int'(af_ofs), y);
          chk("R6", int'(ae_ofs), x);
          chk("R6", int'(load_done), 1);
          // R7: no request, no accept
          wr_req = 1'b0;
          @(negedge clk);
          chk("R7", int'(wr_accept), 0);
          wr_req = 1'b1;
        end
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule